// File: doc/BRIEF.md
# Programmable 16x Baud Rate Generator

This block turns a reference clock into a one-cycle enable pulse whose rate is the reference frequency divided by a 16-bit divisor. A serial transmitter or receiver that oversamples at sixteen times its bit rate uses this pulse as its sampling strobe. The divisor is split into a low byte and a high byte. A CPU bus writes each byte through its own strobe, and both strobes may fire in the same cycle.

The pulse comes from a down-counter. Any write to a divisor byte reloads that counter at once with the newly assembled divisor value. A rate change therefore takes effect on the next period and does not wait for a stale count to expire. A divisor of zero stops the generator. Zero is the reset value, so software must program a nonzero divisor before it relies on the pulse.

Top module: `baud_tick_gen`

## Requirements
- R1: Reset clears both divisor bytes to zero. After reset, `tick` stays low until a nonzero divisor has been written.
- R2: While the assembled divisor is zero, `tick` stays low and the counter holds. This includes the case where zero is written over a divisor that was running.
- R3: `wr_lo` writes `wr_data` into divisor bits 7:0 and `wr_hi` writes it into bits 15:8. The byte that is not written keeps its value. Both strobes may be high in the same cycle.
- R4: A write to either byte loads the counter with the new 16-bit divisor N at that clock edge. The first `tick` is high in the Nth cycle after the write cycle.
- R5: With a steady divisor N of 2 or more, `tick` is high for exactly one cycle in every N cycles.
- R6: With a divisor of 1, `tick` is high in every cycle.
- R7: A write made in the middle of a count discards the remaining count. The next pulse follows the rule in R4 for the new divisor.
- R8: The largest divisor, 65535, gives a pulse period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the divisor low byte |
| wr_hi | input | 1 | Write strobe for the divisor high byte |
| wr_data | input | 8 | Byte written by either strobe |
| tick | output | 1 | One-cycle enable pulse at 16x the bit rate |

## Verification
A write is captured at the rising edge that ends its strobe cycle. `tick` is a decode of the registered count, so for divisor N the first pulse is due N cycles after that edge, and the pulses after it are due every N cycles. The bench drives inputs and samples `tick` on falling edges. It counts falling edges from the first cycle after the write and compares that count with N, so a pulse one cycle early or late changes the measured number. Checks for hold and for no output watch `tick` over a fixed window of several hundred cycles after the stimulus.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CNT_HOLD   = 2'd0,
        CNT_LOAD   = 2'd1,
        CNT_RELOAD = 2'd2,
        CNT_DEC    = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/div_byte_reg.sv
module div_byte_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    typedef struct packed {
        logic [W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.val = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q   = st_q.val;
    assign nxt = st_d.val;
endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import baud_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] div,
    output logic [W-1:0] cnt,
    output logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t     st_d, st_q;
    cnt_op_e op;

    always_comb begin
        if (load)                op = CNT_LOAD;
        else if (div == '0)      op = CNT_HOLD;
        else if (st_q.cnt <= ONE) op = CNT_RELOAD;
        else                     op = CNT_DEC;

        st_d = st_q;
        case (op)
            CNT_LOAD:   st_d.cnt = load_val;
            CNT_HOLD:   st_d.cnt = '0;
            CNT_RELOAD: st_d.cnt = div;
            default:    st_d.cnt = st_q.cnt - ONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign tick = (div != '0) && (st_q.cnt == ONE);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int NUM_BYTES = 2,
    localparam int DIV_W = NUM_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick
);
    logic [NUM_BYTES-1:0] wr_vec;
    logic [DIV_W-1:0]     div_q;
    logic [DIV_W-1:0]     div_d;
    logic [DIV_W-1:0]     cnt_q;
    logic                 wr_any;

    always_comb begin
        wr_vec            = '0;
        wr_vec[0]         = wr_lo;
        wr_vec[NUM_BYTES-1] = wr_vec[NUM_BYTES-1] | wr_hi;
    end

    assign wr_any = |wr_vec;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        div_byte_reg #(.W(BYTE_W)) u_byte (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_vec[b]),
            .din   (wr_data),
            .q     (div_q[b*BYTE_W +: BYTE_W]),
            .nxt   (div_d[b*BYTE_W +: BYTE_W])
        );
    end

    tick_counter #(.W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_any),
        .load_val (div_d),
        .div      (div_q),
        .cnt      (cnt_q),
        .tick     (tick)
    );
endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_any,
    input logic [W-1:0] div,
    input logic [W-1:0] cnt,
    input logic         tick
);
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |-> !tick) else $error("zero divisor ticked"); // R2

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !tick) else $error("tick right after reset"); // R1

    AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_any |=> (cnt == div)) else $error("no reload on write"); // R4

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_any && div != W'(1)) |=> !tick) else $error("wide tick"); // R5

    AST_UNIT_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (div == W'(1) && !wr_any && cnt == W'(1)) |=> tick) else $error("divide-by-one gap"); // R6

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_any && div != '0 && cnt > W'(1)) |=> (cnt == $past(cnt) - W'(1)))
        else $error("count skipped"); // R5
endmodule

bind baud_tick_gen baud_tick_chk #(.W(DIV_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_any (wr_any),
    .div    (div_q),
    .cnt    (cnt_q),
    .tick   (tick)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // {low byte, high byte, expected period}
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        32'h01_00_0001,
        32'h02_00_0002,
        32'h0C_00_000C,
        32'h34_01_0134,
        32'hFF_FF_FFFF
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit lo, input bit hi, input logic [7:0] d);
        @(negedge clk);
        wr_lo = lo; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    task automatic wr_both(input logic [7:0] lo, input logic [7:0] hi);
        wr_byte(1'b1, 1'b0, lo);
        @(negedge clk);
        wr_hi = 1'b1; wr_data = hi;
        @(negedge clk);
        wr_hi = 1'b0;
    endtask

    // counts cycles from the current sample point until tick is seen
    task automatic to_tick(input int lim, output int n);
        n = 1;
        while (!tick && n <= lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic period(input int lim, output int n);
        @(negedge clk);
        to_tick(lim, n);
    endtask

    task automatic count_ticks(input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (tick) n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 tick low in reset", int'(tick), 0);
        rst_n = 1'b1;
        count_ticks(200, n);
        check("R1 no tick before divisor written", n, 0);

        // table walk: both bytes written, then first tick and steady period
        for (int v = 0; v < NVEC; v++) begin
            int exp_p;
            exp_p = int'(VEC[v][15:0]);
            wr_both(VEC[v][31:24], VEC[v][23:16]);
            to_tick(70000, n);
            check("R4 first tick after write", n, exp_p);
            period(70000, n);
            check(exp_p == 65535 ? "R8 period of 65535" : "R5 steady period", n, exp_p);
            if (exp_p >= 2) begin
                @(negedge clk);
                check("R5 tick lasts one cycle", int'(tick), 0);
            end
        end

        // R6: divisor 1 ticks every cycle
        wr_both(8'h01, 8'h00);
        count_ticks(20, n);
        check("R6 divide by one", n, 20);

        // R7: mid-count write
        wr_both(8'hC8, 8'h00);
        repeat (50) @(negedge clk);
        wr_byte(1'b1, 1'b0, 8'h0A);
        to_tick(300, n);
        check("R7 mid-count write restarts count", n, 10);
        period(300, n);
        check("R7 new period kept", n, 10);

        // R2: zero over a running divisor holds
        wr_byte(1'b1, 1'b0, 8'h00);
        count_ticks(300, n);
        check("R2 zero divisor holds", n, 0);

        // R3: single byte writes keep the other byte
        wr_byte(1'b1, 1'b0, 8'h03);
        to_tick(100, n);
        check("R3 low byte alone", n, 3);
        wr_byte(1'b0, 1'b1, 8'h01);
        to_tick(1000, n);
        check("R3 high byte alone keeps low byte", n, 259);
        // both strobes together
        wr_byte(1'b1, 1'b1, 8'h02);
        to_tick(1000, n);
        check("R3 both strobes same cycle", n, 514);

        // R1: reset while running clears divisor
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 tick low during reset", int'(tick), 0);
        rst_n = 1'b1;
        count_ticks(600, n);
        check("R1 divisor cleared by reset", n, 0);
        wr_byte(1'b0, 1'b1, 8'h00);
        count_ticks(100, n);
        check("R2 high byte zero keeps hold", n, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule